// File: doc/BRIEF.md
# Serial Stream Concentrator with Source Tagging

This block funnels twelve bit-serial event streams into one bit-serial output at the same line rate. The design clock runs at the line rate, so one bit moves on every line per clock. Each input line is framed: a 1 start bit followed by an 88-bit event record carrying a timestamp and a hit pattern. Every input has its own receiver, which rebuilds the record, and its own small event queue, which holds whole records until the output can take them.

A round-robin picker chooses among inputs that hold at least one complete record. The output framer sends the chosen record with its source index in front: a start bit, a 4-bit input index, then the 88 record bits. A single shared output is enough because the event rate is low. When a queue is full, a newly completed record from that input is discarded and counted in that input's overflow counter.

Top module: `ssc_concentrator`

## Requirements
- R1: An idle input line is 0. A 1 seen on an idle line is a start bit, and the next 88 bits on that line are the record, most significant bit (bit 87) first.
- R2: While a record is being received, a 1 on the line is data and not a start bit. A new start bit is accepted in the cycle right after the 88th data bit, so records may follow back to back.
- R3: Each output record is 93 bits sent most significant first: a 1 start bit, then the 4-bit input index (0 to 11), then the 88 record bits exactly as received.
- R4: The output is 0 whenever no record is being sent. At least one 0 bit separates consecutive output records.
- R5: Inputs are served round-robin. The search starts at the input after the one served last and wraps from 11 to 0. After reset the search starts at input 0.
- R6: Only an input holding a complete record takes part in the choice. An input that is still receiving is skipped.
- R7: Each input queues up to 4 complete records, and the records of one input leave in the order they arrived.
- R8: A record that completes while its input queue already holds 4 records is discarded. That input's 8-bit saturating overflow counter, at `ovf_count[8*i +: 8]` for input i, then increments by one.
- R9: After reset the output is 0, every overflow counter is 0 and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the line bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 12 | Input lines, bit i is input i |
| ser_out | output | 1 | Tagged, merged output line |
| ovf_count | output | 96 | Overflow counters, 8 bits per input, input i at bits 8*i+7..8*i |

## Verification
The assertions rely on a few input assumptions. Every input line sits at 0 between records and carries only whole frames of a start bit plus 88 bits. Reset is applied only while the lines are quiet. The stimulus meets these by driving complete frames, either alone or several back to back, and by changing the lines only on the falling clock edge. Because it never truncates a frame, a receiver is never left mid-record at a reset. The heavy-load case starts all twelve inputs together, and the arrival and drain times are far enough apart that the set of discarded records does not depend on a single cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;
endpackage

// File: rtl/ssc_deser.sv
module ssc_deser #(
   parameter int REC_W = 88
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_i,
   output logic [REC_W-1:0] rec_o,
   output logic             rec_vld_o
);
   localparam int CW = $clog2(REC_W);

   logic             busy_q;
   logic [CW-1:0]    cnt_q;
   logic [REC_W-1:0] shreg_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         shreg_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (!busy_q) begin
            if (line_i) begin
               busy_q <= 1'b1;
               cnt_q  <= '0;
            end
         end else begin
            shreg_q <= {shreg_q[REC_W-2:0], line_i};
            if (cnt_q == CW'(REC_W-1)) begin
               busy_q <= 1'b0;
               vld_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign rec_o     = shreg_q;
   assign rec_vld_o = vld_q;
endmodule

// File: rtl/ssc_fifo.sv
module ssc_fifo #(
   parameter int W     = 88,
   parameter int DEPTH = 4,
   parameter int OVF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     data_i,
   input  logic             pop_i,
   output logic [W-1:0]     data_o,
   output logic             nempty_o,
   output logic             full_o,
   output logic [OVF_W-1:0] ovf_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [OVF_W-1:0] OVF_MAX = '1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic [OVF_W-1:0] ovf_q;
   logic          acc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign full_o   = (cnt_q == CW'(DEPTH));
   assign nempty_o = (cnt_q != '0);
   assign acc      = push_i && !full_o;
   assign data_o   = mem[rd_q];

   always_ff @(posedge clk) begin
      if (acc) mem[wr_q] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovf_q <= '0;
      end else begin
         if (acc) wr_q <= wr_nxt;
         if (pop_i) rd_q <= rd_nxt;
         case ({acc, pop_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push_i && full_o && ovf_q != OVF_MAX) ovf_q <= ovf_q + 1'b1;
      end
   end

   assign ovf_o = ovf_q;
endmodule

// File: rtl/ssc_rr_arb.sv
module ssc_rr_arb #(
   parameter int N = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req_i,
   input  logic                 take_i,
   output logic [$clog2(N)-1:0] idx_o,
   output logic                 any_o
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] last_q;
   logic [IW-1:0] sel;
   logic          found;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int k = 1; k <= N; k++) begin
         int c;
         c = int'(last_q) + k;
         if (c >= N) c = c - N;
         if (!found && req_i[c]) begin
            found = 1'b1;
            sel   = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= IW'(N-1);
      else if (take_i) last_q <= sel;
   end

   assign idx_o = sel;
   assign any_o = found;
endmodule

// File: rtl/ssc_ser.sv
module ssc_ser #(
   parameter int REC_W = 88,
   parameter int ID_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ready_i,
   input  logic [ID_W-1:0]  id_i,
   input  logic [REC_W-1:0] data_i,
   output logic             load_o,
   output logic             busy_o,
   output logic             line_o
);
   import ssc_pkg::*;
   localparam int TOT = 1 + ID_W + REC_W;
   localparam int CW  = $clog2(TOT);

   tx_state_e      st_q;
   logic [TOT-1:0] sh_q;
   logic [CW-1:0]  cnt_q;

   assign load_o = (st_q == TX_IDLE) && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TX_IDLE;
         sh_q  <= '0;
         cnt_q <= '0;
      end else begin
         case (st_q)
            TX_IDLE: if (load_o) begin
               sh_q  <= {1'b1, id_i, data_i};
               cnt_q <= '0;
               st_q  <= TX_SEND;
            end
            TX_SEND: begin
               sh_q <= {sh_q[TOT-2:0], 1'b0};
               if (cnt_q == CW'(TOT-1)) st_q <= TX_IDLE;
               else cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q == TX_SEND);
   assign line_o = busy_o && sh_q[TOT-1];
endmodule

// File: rtl/ssc_concentrator.sv
module ssc_concentrator #(
   parameter int N_IN   = 12,
   parameter int REC_W  = 88,
   parameter int QDEPTH = 4,
   parameter int OVF_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_IN-1:0]       ser_in,
   output logic                  ser_out,
   output logic [N_IN*OVF_W-1:0] ovf_count
);
   localparam int ID_W = $clog2(N_IN);

   generate
      if (N_IN < 2)    begin : g_bad_n   $error("N_IN must be at least 2");   end
      if (REC_W < 2)   begin : g_bad_w   $error("REC_W must be at least 2");  end
      if (QDEPTH < 2)  begin : g_bad_d   $error("QDEPTH must be at least 2"); end
      if (OVF_W < 1)   begin : g_bad_o   $error("OVF_W must be positive");    end
   endgenerate

   logic [REC_W-1:0] rec_data  [N_IN];
   logic [REC_W-1:0] fifo_dout [N_IN];
   logic [N_IN-1:0]  rec_vld, fifo_ne, fifo_full, pop_vec;
   logic [ID_W-1:0]  arb_idx;
   logic             arb_any, tx_load, tx_busy;
   logic [REC_W-1:0] sel_data;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_lane
         ssc_deser #(.REC_W(REC_W)) u_rx (
            .clk(clk), .rst_n(rst_n), .line_i(ser_in[i]),
            .rec_o(rec_data[i]), .rec_vld_o(rec_vld[i])
         );
         ssc_fifo #(.W(REC_W), .DEPTH(QDEPTH), .OVF_W(OVF_W)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push_i(rec_vld[i]), .data_i(rec_data[i]),
            .pop_i(pop_vec[i]), .data_o(fifo_dout[i]),
            .nempty_o(fifo_ne[i]), .full_o(fifo_full[i]),
            .ovf_o(ovf_count[i*OVF_W +: OVF_W])
         );
         assign pop_vec[i] = tx_load && (arb_idx == ID_W'(i));
      end
   endgenerate

   ssc_rr_arb #(.N(N_IN)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(fifo_ne), .take_i(tx_load),
      .idx_o(arb_idx), .any_o(arb_any)
   );

   assign sel_data = fifo_dout[arb_idx];

   ssc_ser #(.REC_W(REC_W), .ID_W(ID_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .ready_i(arb_any), .id_i(arb_idx),
      .data_i(sel_data), .load_o(tx_load), .busy_o(tx_busy), .line_o(ser_out)
   );
endmodule

// File: rtl/ssc_concentrator_chk.sv
module ssc_concentrator_chk #(
   parameter int N_IN  = 12,
   parameter int REC_W = 88,
   parameter int OVF_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ser_out,
   input logic                  tx_busy,
   input logic [N_IN-1:0]       pop_vec,
   input logic [N_IN-1:0]       fifo_ne,
   input logic [N_IN-1:0]       fifo_full,
   input logic [N_IN-1:0]       rec_vld,
   input logic [N_IN*OVF_W-1:0] ovf_count
);
   localparam int TOT = 1 + $clog2(N_IN) + REC_W;

   logic [15:0] len_q;
   always_ff @(posedge clk) begin
      if (!rst_n) len_q <= '0;
      else if (tx_busy) len_q <= len_q + 1'b1;
      else len_q <= '0;
   end

   AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> ser_out); // R3
   AST_REC_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_busy) |-> (len_q == 16'(TOT))); // R3
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) ($past(fifo_ne) == '0 && !$past(tx_busy)) |-> !ser_out); // R4
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pop_vec)); // R5
   AST_POP_READY: assert property (@(posedge clk) disable iff (!rst_n) (pop_vec & ~fifo_ne) == '0); // R6

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_ovf
         AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_count[i*OVF_W +: OVF_W] == $past(ovf_count[i*OVF_W +: OVF_W])) ||
            (ovf_count[i*OVF_W +: OVF_W] == $past(ovf_count[i*OVF_W +: OVF_W]) + 1'b1)); // R8
         AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_count[i*OVF_W +: OVF_W] != $past(ovf_count[i*OVF_W +: OVF_W])) |->
            $past(fifo_full[i] && rec_vld[i])); // R8
      end
   endgenerate
endmodule

bind ssc_concentrator ssc_concentrator_chk #(.N_IN(N_IN), .REC_W(REC_W), .OVF_W(OVF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .tx_busy(tx_busy),
   .pop_vec(pop_vec), .fifo_ne(fifo_ne), .fifo_full(fifo_full),
   .rec_vld(rec_vld), .ovf_count(ovf_count)
);

// File: tb/ssc_concentrator_tb_top.sv
`timescale 1ns/1ps
module ssc_concentrator_tb_top;
   localparam int CLK_PERIOD = 100;
   localparam int N = 12;
   localparam int RW = 88;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  ser_in = '0;
   logic          ser_out;
   logic [N*8-1:0] ovf_count;

   int n_chk = 0;
   int n_err = 0;
   string cur_req = "R9";
   logic [91:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ssc_concentrator dut_i (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
      .ser_out(ser_out), .ovf_count(ovf_count)
   );

   function automatic logic [RW-1:0] mk(int ch, int seq);
      return {8'(ch), 16'(seq), 32'hC3A5_5A3C ^ 32'(seq * 7919), 32'(ch * 1000003 + seq)};
   endfunction

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_exp(int ch, logic [RW-1:0] d);
      exp_q.push_back({4'(ch), d});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic drive_one(int ch, logic [RW-1:0] d);
      for (int b = 0; b <= RW; b++) begin
         @(negedge clk);
         ser_in[ch] = (b == 0) ? 1'b1 : d[RW-b];
      end
      @(negedge clk);
      ser_in[ch] = 1'b0;
   endtask

   task automatic drive_multi(logic [N-1:0] mask, int nrec, int seq0);
      for (int r = 0; r < nrec; r++) begin
         for (int b = 0; b <= RW; b++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
               if (mask[i]) begin
                  logic [RW-1:0] d;
                  d = mk(i, seq0 + r);
                  ser_in[i] = (b == 0) ? 1'b1 : d[RW-b];
               end
            end
         end
      end
      @(negedge clk);
      ser_in = ser_in & ~mask;
   endtask

   task automatic drain();
      for (int t = 0; t < 30000 && exp_q.size() != 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(cur_req, 128'(exp_q.size()), 128'd0);
   endtask

   // monitor: pops expected records as the output line produces them
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ser_out) begin
            logic [91:0] got;
            logic [91:0] want;
            got = '0;
            for (int b = 0; b < 92; b++) begin
               @(negedge clk);
               got = {got[90:0], ser_out};
            end
            if (exp_q.size() == 0) begin
               n_chk++; n_err++;
               $display("FAIL %s actual=%0h expected=none (unexpected record)", cur_req, got);
            end else begin
               want = exp_q.pop_front();
               check(cur_req, 128'(got), 128'(want));  // R3 framing and content
            end
            @(negedge clk);
            check("R4", 128'(ser_out), 128'd0);  // R4 gap bit after a record
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic idle_bad;
      do_reset();
      // R9: quiet output and zero counters after reset
      idle_bad = 1'b0;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (ser_out) idle_bad = 1'b1;
      end
      check("R9", 128'(idle_bad), 128'd0);
      check("R9", 128'(ovf_count), 128'd0);

      // R1 / R3: single record tagged with its input index
      cur_req = "R1";
      push_exp(9, mk(9, 1));
      drive_one(9, mk(9, 1));
      drain();

      // R2: all-ones record must not restart reception mid-frame
      cur_req = "R2";
      push_exp(6, '1);
      drive_one(6, '1);
      drain();

      // R2 / R7: three back-to-back records on input 0 keep their order
      cur_req = "R7";
      for (int r = 0; r < 3; r++) push_exp(0, mk(0, 10 + r));
      drive_multi(12'h001, 3, 10);
      drain();

      // R5: wrap-around from last served input 9
      do_reset();
      cur_req = "R5";
      push_exp(9, mk(9, 20));
      drive_multi(12'h200, 1, 20);
      drain();
      push_exp(11, mk(11, 21));
      push_exp(2, mk(2, 21));
      drive_multi(12'h804, 1, 21);
      drain();
      push_exp(3, mk(3, 22));
      push_exp(5, mk(5, 22));
      push_exp(7, mk(7, 22));
      drive_multi(12'h0A8, 1, 22);
      drain();

      // R6: a lower input still receiving is skipped
      do_reset();
      cur_req = "R6";
      push_exp(10, mk(10, 30));
      push_exp(5, mk(5, 31));
      fork
         drive_one(10, mk(10, 30));
         begin
            repeat (40) @(negedge clk);
            drive_one(5, mk(5, 31));
         end
      join
      drain();

      // R8 / R7: all inputs send five records together; inputs 4..11 lose the fifth
      do_reset();
      cur_req = "R8";
      for (int r = 0; r < 4; r++)
         for (int k = 0; k < N; k++) push_exp(k, mk(k, 100 + r));
      for (int k = 0; k < 4; k++) push_exp(k, mk(k, 104));
      drive_multi('1, 5, 100);
      drain();
      for (int k = 0; k < N; k++)
         check("R8", 128'(ovf_count[k*8 +: 8]), (k < 4) ? 128'd0 : 128'd1);

      // R9: reset clears overflow counters
      do_reset();
      check("R9", 128'(ovf_count), 128'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule